// File: doc/BRIEF.md
# MDIO Management Frame Master

This block sends management frames to an Ethernet PHY over a two-wire serial link: a management clock that it divides down from the system clock, and one shared data line. A host hands it one command at a time. A command is read or write, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block then shifts out a 64-bit frame. When the frame ends it pulses `done`. After a read, the 16 bits the PHY returned are on `rd_data`.

The data line is open-drain. The block has only an enable that pulls the pad low. A 0 is sent by pulling the line low and a 1 by releasing it. The pad's read-back value comes in on `mdio_in`. During a read, the block releases the line from the first turnaround bit to the end of the payload, so the PHY alone drives the returned bits. Outgoing bits change when the management clock falls, and incoming bits are sampled when it rises. The management clock stays high between frames. The divider parameter sets the rate: a half-period of 10 system clocks gives 12.5 MHz from 250 MHz, and 25 gives 5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc` is high, `mdio_oe` is low, and `busy` and `done` are low.
- R2: A frame is 64 bits. The first 32 bits are ones. Every 1 is sent with `mdio_oe` low (line released), and every 0 with `mdio_oe` high (line pulled low).
- R3: Bits 32..35 are the start pattern 0,1 followed by the opcode: 0,1 for a write and 1,0 for a read.
- R4: Bits 36..40 carry the PHY address and bits 41..45 the register address, each most-significant bit first.
- R5: On a write, bits 46..47 are the turnaround 1,0 and bits 48..63 are the write data, most-significant bit first.
- R6: On a read, `mdio_oe` stays low for bits 46..63. On the rising `mdc` edge of each of bits 48..63, the bit on `mdio_in` is shifted in, most-significant bit first. The result is on `rd_data` from the cycle `done` is high.
- R7: Each bit lasts 2*HALF_DIV system clocks. `mdc` is low for the first HALF_DIV clocks and high for the last HALF_DIV. `mdc` falls in the first cycle after the command is accepted.
- R8: A command is accepted when `cmd_valid` is high while `busy` is low. `busy` is high from the next cycle until the frame ends. While `busy` is high, `cmd_valid` is ignored.
- R9: `done` is high for exactly one cycle, 128*HALF_DIV clock edges after the accepting edge. In that same cycle `busy` falls.
- R10: A write frame leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write payload |
| busy | output | 1 | Frame in progress; commands are ignored |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock, idles high |
| mdio_oe | output | 1 | Pulls the data line low when high |
| mdio_in | input | 1 | Sampled level of the data line |

## Verification
The assertions check on every cycle that the clock idles high outside a frame and that the line is never pulled during a read's turnaround and payload. They also check that the enable changes only where the clock falls or the frame ends, and that `done` is a single cycle that ends `busy`. Only the bench's scenarios can show the content of each field, the exact bit timing, and that the returned word is assembled in the right order. The same holds for ignored mid-frame requests, back-to-back commands, and `rd_data` staying unchanged across writes.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int CW         = $clog2(HALF_DIV + 1);
  localparam int FRAME_BITS = 64;
  localparam int DATA_START = 48;

  logic [CW-1:0] cnt;
  logic [5:0]    idx;
  logic [63:0]   sh;
  logic          rd_op;
  logic          accept;
  logic          half_end;
  logic [63:0]   frame;

  assign accept   = cmd_valid & ~busy;
  assign half_end = (cnt == CW'(HALF_DIV - 1));
  assign frame    = {32'hFFFF_FFFF, 2'b01, (cmd_write ? 2'b01 : 2'b10), cmd_phy, cmd_reg,
                     (cmd_write ? {2'b10, cmd_wdata} : 18'h3FFFF)};
  assign mdio_oe  = busy & ~sh[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b1;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '1;
      rd_op   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        mdc   <= 1'b0;
        cnt   <= '0;
        idx   <= '0;
        sh    <= frame;
        rd_op <= ~cmd_write;
      end else if (busy) begin
        if (!half_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!mdc) begin
            mdc <= 1'b1;
            if (rd_op && idx >= 6'(DATA_START))
              rd_data <= {rd_data[14:0], mdio_in};
          end else if (idx == 6'(FRAME_BITS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            mdc <= 1'b0;
            idx <= idx + 1'b1;
            sh  <= {sh[62:0], 1'b1};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       busy,
  input logic       done,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       rd_op,
  input logic [5:0] idx
);
  AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mdc); // R1

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op && idx >= 6'd46) |-> !mdio_oe); // R6

  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> ($fell(mdc) || done)); // R7

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .mdc(mdc), .mdio_oe(mdio_oe), .rd_op(rd_op), .idx(idx)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, mdc, mdio_oe, mdio_in;
  logic [15:0] rd_data;
  logic phy_pull = 1'b0;

  always #2 clk = ~clk;
  assign mdio_in = ~(mdio_oe | phy_pull);

  mdio_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy),
    .done(done), .rd_data(rd_data), .mdc(mdc), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int vectors = 0, errors = 0, cycles = 0;
  logic [15:0] next_phy_data = '0;

  bit m_busy = 0, m_done = 0, m_read = 0;
  int m_t = 0;
  bit m_bits[64];
  logic [15:0] m_phydata = '0, m_rd = '0;

  task automatic build(input bit wr, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    bit q[$];
    repeat (32) q.push_back(1'b1);
    q.push_back(1'b0); q.push_back(1'b1);
    if (wr) begin q.push_back(1'b0); q.push_back(1'b1); end
    else    begin q.push_back(1'b1); q.push_back(1'b0); end
    for (int i = 4; i >= 0; i--) q.push_back(p[i]);
    for (int i = 4; i >= 0; i--) q.push_back(r[i]);
    if (wr) begin
      q.push_back(1'b1); q.push_back(1'b0);
      for (int i = 15; i >= 0; i--) q.push_back(d[i]);
    end else repeat (18) q.push_back(1'b1);
    for (int i = 0; i < 64; i++) m_bits[i] = q[i];
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_t = 0; m_rd = '0; m_read = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == 128 * H) begin
          m_busy = 0; m_done = 1;
          if (m_read) m_rd = m_phydata;
        end
      end else if (cmd_valid) begin
        m_busy = 1; m_t = 0; m_read = !cmd_write;
        m_phydata = next_phy_data;
        build(cmd_write, cmd_phy, cmd_reg, cmd_wdata);
      end
    end
  end

  task automatic miss(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h (t=%0d)", req, what, act, exp, m_t);
  endtask

  always @(negedge clk) begin
    int k;
    bit e_mdc, e_oe;
    string req;
    k = m_t / (2 * H);
    e_mdc = m_busy ? ((m_t % (2 * H)) >= H) : 1'b1;
    e_oe  = m_busy && !m_bits[k];
    if (!m_busy) req = "R1";
    else if (k < 32) req = "R2";
    else if (k < 36) req = "R3";
    else if (k < 46) req = "R4";
    else req = m_read ? "R6" : "R5";
    vectors++;
    if (mdc !== e_mdc) miss(m_busy ? "R7" : "R1", "mdc", 16'(mdc), 16'(e_mdc));
    if (mdio_oe !== e_oe) miss(req, "mdio_oe", 16'(mdio_oe), 16'(e_oe));
    if (busy !== m_busy) miss("R8", "busy", 16'(busy), 16'(m_busy));
    if (done !== m_done) miss("R9", "done", 16'(done), 16'(m_done));
    if (!m_busy && rd_data !== m_rd) miss(m_read ? "R6" : "R10", "rd_data", rd_data, m_rd);
    if (m_busy && m_read && k == 47) phy_pull = 1'b1;
    else if (m_busy && m_read && k >= 48) phy_pull = ~m_phydata[63 - k];
    else phy_pull = 1'b0;
  end

  task automatic issue(input bit wr, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = p; cmd_reg = r; cmd_wdata = d;
    do @(negedge clk); while (!(m_busy && m_t == 0));
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) if (cycles == 150000) begin
    errors++;
    $display("FAIL R8 watchdog: busy %b expected 0", busy);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5 write with mixed payload
    issue(1'b1, 5'h01, 5'h00, 16'h2100); wait_idle();
    // R6 read returning a pattern
    next_phy_data = 16'hA5C3;
    issue(1'b0, 5'h01, 5'h03, 16'h0000); wait_idle();
    // R10 write after read keeps rd_data
    issue(1'b1, 5'h1F, 5'h0A, 16'h4000); wait_idle();
    issue(1'b1, 5'h00, 5'h1F, 16'hFFFF); wait_idle();
    issue(1'b1, 5'h15, 5'h0A, 16'h0000); wait_idle();
    // R6 all-ones and all-zeros replies
    next_phy_data = 16'hFFFF;
    issue(1'b0, 5'h00, 5'h00, 16'h0); wait_idle();
    next_phy_data = 16'h0000;
    issue(1'b0, 5'h1F, 5'h1F, 16'h0); wait_idle();
    // R8 request during a frame is ignored
    next_phy_data = 16'h8001;
    issue(1'b0, 5'h0A, 5'h15, 16'h0);
    repeat (300) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_wdata = 16'h1234;
    repeat (40) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    // R9 back-to-back: second command held across done
    next_phy_data = 16'h3C5A;
    issue(1'b1, 5'h02, 5'h04, 16'h0F0F);
    issue(1'b0, 5'h03, 5'h05, 16'h0);
    wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule